// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block lets a host reach the management registers of an Ethernet PHY over the two-wire management bus. The two wires are a management clock and a bidirectional data line. The host uses a small 16-bit register port with six registers: mode, command, PHY address, transmit data, receive data and status. The block divides the system clock down to make the management clock, MDC. It shifts out standard read and write frames and samples the PHY's reply during read frames. The data line leaves the block as a value and an output enable, meant for a tri-state pad, and comes back as a separate input.

A host starts a transfer by setting a command bit. The start bits for write and read clear themselves once the frame engine takes the operation. A scan bit makes the engine poll the addressed register again and again. Each scan result updates a link-failure flag, and a not-yet-valid flag covers the time before the first result arrives. A command written while a frame is running waits until that frame has ended.

The frame engine has five states:
- `FR_IDLE`: waiting for a request.
- `FR_PREAMBLE`: sending ones.
- `FR_HEADER`: sending the start, opcode and addresses.
- `FR_TURN`: the two turnaround bits.
- `FR_DATA`: the sixteen data bits.

Its transitions, all taken on a falling-tick of MDC, are:
- accept: `FR_IDLE` to `FR_PREAMBLE`, or to `FR_HEADER` when the preamble is suppressed.
- preamble-done: `FR_PREAMBLE` to `FR_HEADER`.
- header-done: `FR_HEADER` to `FR_TURN`.
- turn-done: `FR_TURN` to `FR_DATA`.
- frame-done: `FR_DATA` to `FR_IDLE`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register offsets on `host_addr` are 0 mode, 1 command, 2 PHY address, 3 transmit data, 4 receive data and 5 status. Offsets 6 and 7 read as zero. The mode register holds the clock divider in bits 7:0 and the preamble-suppress bit at bit 8, reads zero above bit 8, and resets to 0x0064.
- R2: With preamble-suppress clear, every frame begins with 32 driven ones. With it set, the frame begins directly with the start bits.
- R3: In the command register, bit 2 starts a write and bit 1 starts a read. A host write loads all three low bits. The write and read start bits read as zero from the cycle after the engine accepts the operation.
- R4: The address register keeps the PHY register number in bits 12:8 and the PHY number in bits 4:0. All other bits read as zero, whatever value was written.
- R5: Command bit 0 enables scan. It stays set until the host clears it. While it is set, read frames of the addressed register repeat, and after it is cleared no further frame starts.
- R6: When a read or scan frame ends, its 16 data bits, first-received bit as MSB, appear at receive data (offset 4). That register resets to zero.
- R7: Status (offset 5) reads bit 2 not-yet-valid, bit 1 busy and bit 0 link-fail, with zeros above. Not-yet-valid is set when scan is switched on and is cleared by the first captured scan result. Link-fail is the inverse of bit 2 of the latest scan result.
- R8: Busy is high from the cycle after a host sets a write or read bit until the frame ends, and is low once the engine is idle with no write or read pending.
- R9: A frame is sent MSB first as start bits 01, then the opcode (10 for read, 01 for write), the 5-bit PHY number, the 5-bit register number, and 16 data bits. On a write, the data bits come from transmit data (offset 3).
- R10: On a write, the turnaround bits are driven as 1 then 0. On a read, the output enable is low through the turnaround and data bits.
- R11: A command written while busy waits until the running frame ends. When several requests are pending, write goes first, then read, then scan.
- R12: One MDC period lasts max(divider, 2) system clocks. The data-line outputs change only in the cycle where MDC falls, and read bits are taken on the cycle where MDC rises.
- R13: Host writes to the receive data and status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value to the pad |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value from the pad |

## Verification
The assertions check on every cycle that:
- the data-line outputs move only on the falling tick of MDC;
- the line is released through the turnaround and data of read frames;
- accepted start bits clear, and the scan bit holds;
- busy covers every active frame;
- a read is never taken ahead of a pending write.

Only the bench scenarios can show the rest:
- the full bit sequence of each frame, with and without preamble;
- the MDC period for large and clamped divider values;
- the value captured from the PHY;
- the queueing of a command written mid-frame;
- the scan flags;
- the fact that a cleared scan starts no further frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_PREAMBLE,
        FR_HEADER,
        FR_TURN,
        FR_DATA
    } frame_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_READ,
        OP_SCAN
    } op_kind_e;

    localparam logic [2:0] OFS_MODE   = 3'd0;
    localparam logic [2:0] OFS_CMD    = 3'd1;
    localparam logic [2:0] OFS_ADDR   = 3'd2;
    localparam logic [2:0] OFS_TXDATA = 3'd3;
    localparam logic [2:0] OFS_RXDATA = 3'd4;
    localparam logic [2:0] OFS_STATUS = 3'd5;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        eff       = (div < MIN_DIV) ? MIN_DIV : div;
        half      = eff >> 1;
        fall_tick = (cnt_q >= eff - ONE);
        rise_tick = !fall_tick && (cnt_q == half - ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= fall_tick ? '0 : cnt_q + ONE;
            if (fall_tick)
                mdc <= 1'b0;
            else if (rise_tick)
                mdc <= 1'b1;
        end
    end

    // R12: a rising tick is always followed by a falling tick before the next rise
    assert_rise_then_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> !rise_tick)
        else $error("R12 two rising ticks in a row");

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              no_preamble,
    input  logic              req_write,
    input  logic              req_read,
    input  logic              req_scan,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              active,
    output logic              acc_write,
    output logic              acc_read,
    output logic              cap_valid,
    output logic              cap_scan,
    output logic [DATA_W-1:0] cap_data
);
    localparam int HDR_W   = 4 + 2 * ADDR_W;
    localparam int LEN_A   = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int MAX_LEN = (LEN_A > HDR_W) ? LEN_A : HDR_W;
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam int HIDX_W  = $clog2(HDR_W);
    localparam int DIDX_W  = $clog2(DATA_W);

    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    op_kind_e          op_q, pick;
    logic [HDR_W-1:0]  hdr_q, hdr_new, hdr_src;
    logic [DATA_W-1:0] txd_q;
    logic [DATA_W-1:0] rx_shift;
    logic              start;
    logic              wr_kind;
    logic              bit_d, oe_d;

    // request selection: write over read over scan
    always_comb begin
        if (req_write)
            pick = OP_WRITE;
        else if (req_read)
            pick = OP_READ;
        else if (req_scan)
            pick = OP_SCAN;
        else
            pick = OP_NONE;
        start     = (state_q == FR_IDLE) && fall_tick && (pick != OP_NONE);
        acc_write = start && (pick == OP_WRITE);
        acc_read  = start && (pick == OP_READ);
        hdr_new   = {2'b01, (pick == OP_WRITE) ? 2'b01 : 2'b10, phy_addr, reg_addr};
        hdr_src   = start ? hdr_new : hdr_q;
        wr_kind   = start ? (pick == OP_WRITE) : (op_q == OP_WRITE);
    end

    // next-state logic, advanced once per falling tick
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fall_tick) begin
            unique case (state_q)
                FR_IDLE: begin
                    if (start) begin
                        if (no_preamble) begin
                            state_d = FR_HEADER;
                            cnt_d   = CNT_W'(HDR_W - 1);
                        end else begin
                            state_d = FR_PREAMBLE;
                            cnt_d   = CNT_W'(PRE_LEN - 1);
                        end
                    end
                end
                FR_PREAMBLE: begin
                    if (cnt_q == '0) begin
                        state_d = FR_HEADER;
                        cnt_d   = CNT_W'(HDR_W - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                FR_HEADER: begin
                    if (cnt_q == '0) begin
                        state_d = FR_TURN;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                FR_TURN: begin
                    if (cnt_q == '0) begin
                        state_d = FR_DATA;
                        cnt_d   = CNT_W'(DATA_W - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                FR_DATA: begin
                    if (cnt_q == '0) begin
                        state_d = FR_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // line value for the bit that starts with the next state
    always_comb begin
        bit_d = 1'b0;
        oe_d  = 1'b0;
        unique case (state_d)
            FR_IDLE: begin
                bit_d = 1'b0;
                oe_d  = 1'b0;
            end
            FR_PREAMBLE: begin
                bit_d = 1'b1;
                oe_d  = 1'b1;
            end
            FR_HEADER: begin
                bit_d = hdr_src[cnt_d[HIDX_W-1:0]];
                oe_d  = 1'b1;
            end
            FR_TURN: begin
                bit_d = wr_kind && (cnt_d != '0);
                oe_d  = wr_kind;
            end
            FR_DATA: begin
                bit_d = wr_kind && txd_q[cnt_d[DIDX_W-1:0]];
                oe_d  = wr_kind;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs and frame data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            hdr_q    <= '0;
            txd_q    <= '0;
            rx_shift <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            if (start) begin
                op_q  <= pick;
                hdr_q <= hdr_new;
                txd_q <= tx_data;
            end
            if (fall_tick) begin
                mdio_o  <= bit_d;
                mdio_oe <= oe_d;
            end
            if (rise_tick && state_q == FR_DATA)
                rx_shift <= {rx_shift[DATA_W-2:0], mdio_i};
        end
    end

    always_comb begin
        active    = (state_q != FR_IDLE);
        cap_valid = rise_tick && (state_q == FR_DATA) && (cnt_q == '0) && (op_q != OP_WRITE);
        cap_scan  = (op_q == OP_SCAN);
        cap_data  = {rx_shift[DATA_W-2:0], mdio_i};
    end

    // R12: line outputs move only on the falling tick
    assert_line_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(mdio_o) && $stable(mdio_oe))
        else $error("R12 data line changed away from falling tick");

    // R10: line released through turnaround and data of read frames
    assert_read_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FR_TURN || state_q == FR_DATA) && op_q != OP_WRITE) |-> !mdio_oe)
        else $error("R10 line driven during read reply");

    // R11: a read is never taken while a write is requested
    assert_write_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_read |-> !req_write)
        else $error("R11 read accepted ahead of write");

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int          DIV_W      = 8,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 5,
    parameter logic [15:0] MODE_RESET = 16'h0064
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DIV_W-1:0]  div,
    output logic              no_preamble,
    output logic              req_write,
    output logic              req_read,
    output logic              req_scan,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] tx_data,
    input  logic              acc_write,
    input  logic              acc_read,
    input  logic              frame_active,
    input  logic              cap_valid,
    input  logic              cap_scan,
    input  logic [DATA_W-1:0] cap_data
);
    localparam int REG_LSB = 8;
    localparam int MODE_W  = DIV_W + 1;

    logic [MODE_W-1:0] mode_q;
    logic [2:0]        cmd_q;
    logic [ADDR_W-1:0] phy_q, regad_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              stale_q, linkfail_q, busy;
    logic              wr_mode, wr_cmd, wr_addr, wr_tx;

    always_comb begin
        wr_mode = host_wr && (host_addr == OFS_MODE);
        wr_cmd  = host_wr && (host_addr == OFS_CMD);
        wr_addr = host_wr && (host_addr == OFS_ADDR);
        wr_tx   = host_wr && (host_addr == OFS_TXDATA);
        busy    = frame_active || cmd_q[2] || cmd_q[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_RESET[MODE_W-1:0];
            cmd_q      <= '0;
            phy_q      <= '0;
            regad_q    <= '0;
            tx_q       <= '0;
            rx_q       <= '0;
            stale_q    <= 1'b0;
            linkfail_q <= 1'b0;
        end else begin
            if (wr_mode)
                mode_q <= host_wdata[MODE_W-1:0];
            if (wr_addr) begin
                regad_q <= host_wdata[REG_LSB +: ADDR_W];
                phy_q   <= host_wdata[ADDR_W-1:0];
            end
            if (wr_tx)
                tx_q <= host_wdata;
            if (wr_cmd) begin
                cmd_q <= host_wdata[2:0];
            end else begin
                if (acc_write)
                    cmd_q[2] <= 1'b0;
                if (acc_read)
                    cmd_q[1] <= 1'b0;
            end
            if (cap_valid)
                rx_q <= cap_data;
            if (cap_valid && cap_scan)
                linkfail_q <= !cap_data[2];
            if (wr_cmd && host_wdata[0] && !cmd_q[0])
                stale_q <= 1'b1;
            else if (cap_valid && cap_scan)
                stale_q <= 1'b0;
            else if (!cmd_q[0])
                stale_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_MODE:   host_rdata[MODE_W-1:0] = mode_q;
            OFS_CMD:    host_rdata[2:0] = cmd_q;
            OFS_ADDR: begin
                host_rdata[REG_LSB +: ADDR_W] = regad_q;
                host_rdata[ADDR_W-1:0]        = phy_q;
            end
            OFS_TXDATA: host_rdata = tx_q;
            OFS_RXDATA: host_rdata = rx_q;
            OFS_STATUS: host_rdata[2:0] = {stale_q, busy, linkfail_q};
            default:    host_rdata = '0;
        endcase
    end

    always_comb begin
        div         = mode_q[DIV_W-1:0];
        no_preamble = mode_q[DIV_W];
        req_write   = cmd_q[2];
        req_read    = cmd_q[1];
        req_scan    = cmd_q[0];
        phy_addr    = phy_q;
        reg_addr    = regad_q;
        tx_data     = tx_q;
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = &{1'b0, host_wdata};

    // R3: an accepted write start bit reads zero next cycle
    assert_autoclear_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && !wr_cmd) |=> !cmd_q[2])
        else $error("R3 write start bit did not clear");

    assert_autoclear_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_read && !wr_cmd) |=> !cmd_q[1])
        else $error("R3 read start bit did not clear");

    // R5: scan bit holds without a host write
    assert_scan_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[0] && !wr_cmd) |=> cmd_q[0])
        else $error("R5 scan bit dropped by itself");

    // R7: a captured scan result clears not-yet-valid
    assert_stale_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_scan && !wr_cmd) |=> !stale_q)
        else $error("R7 not-yet-valid stuck after scan result");

    // R8: busy covers every active frame
    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active |-> busy)
        else $error("R8 busy low during frame");

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
    parameter int          DIV_W      = 8,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 5,
    parameter int          PRE_LEN    = 32,
    parameter logic [15:0] MODE_RESET = 16'h0064
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [DIV_W-1:0]  div;
    logic              no_preamble, req_write, req_read, req_scan;
    logic [ADDR_W-1:0] phy_addr, reg_addr;
    logic [DATA_W-1:0] tx_data, cap_data;
    logic              acc_write, acc_read, frame_active;
    logic              cap_valid, cap_scan;
    logic              rise_tick, fall_tick;

    mdio_regs #(
        .DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_RESET(MODE_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .div(div), .no_preamble(no_preamble),
        .req_write(req_write), .req_read(req_read), .req_scan(req_scan),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .tx_data(tx_data),
        .acc_write(acc_write), .acc_read(acc_read), .frame_active(frame_active),
        .cap_valid(cap_valid), .cap_scan(cap_scan), .cap_data(cap_data)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .div(div),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame #(
        .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_frame (
        .clk(clk), .rst_n(rst_n),
        .rise_tick(rise_tick), .fall_tick(fall_tick),
        .no_preamble(no_preamble),
        .req_write(req_write), .req_read(req_read), .req_scan(req_scan),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .tx_data(tx_data),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .active(frame_active), .acc_write(acc_write), .acc_read(acc_read),
        .cap_valid(cap_valid), .cap_scan(cap_scan), .cap_data(cap_data)
    );

endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_out = 1'b1;
    logic [15:0] phy_val = 16'h0;

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_out;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int total = 0;
    int bad = 0;

    typedef struct packed {
        logic       rd;
        logic [5:0] pre;
        logic [4:0] phy;
        logic [4:0] rg;
        logic [15:0] dat;
    } frame_t;

    frame_t exp_q[$];
    frame_t scan_tpl;
    logic   scan_on = 1'b0;
    int     frames_seen = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, s);
            if (!s[1]) break;
        end
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (frames_seen >= target) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input logic r, input logic [5:0] p, input logic [4:0] ph,
                        input logic [4:0] g, input logic [15:0] d);
        frame_t f;
        f.rd = r; f.pre = p; f.phy = ph; f.rg = g; f.dat = d;
        exp_q.push_back(f);
    endtask

    // monitor: decodes frames as seen on the pins and compares with the queue
    logic        prev_mdc = 1'b0, prev_out = 1'b0, prev_oe = 1'b0;
    int          mphase = 0, ones = 0, hcnt = 0, tcnt = 0, dcnt = 0;
    logic [12:0] h = '0;
    logic [1:0]  ta_oe = '0, ta_bit = '0;
    logic [15:0] dat = '0;
    logic        cur_rd = 1'b0;
    int          period_cnt = 0, last_period = 0, viol = 0;

    task automatic finish_frame();
        frame_t e;
        logic   ok;
        frames_seen++;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
        end else if (scan_on) begin
            e = scan_tpl;
        end else begin
            check(1'b0, "R5 R11 unexpected frame", {19'h0, h}, 32'h0);
            return;
        end
        ok = (ones == int'(e.pre)) && h[12] && (h[11:10] == (e.rd ? 2'b10 : 2'b01)) &&
             (h[9:5] == e.phy) && (h[4:0] == e.rg) &&
             (e.rd ? (ta_oe == 2'b00) : (ta_oe == 2'b11 && ta_bit == 2'b10 && dat == e.dat));
        check(ok, "R2 R9 R10 frame content",
              {ones[5:0], h, ta_oe, ta_bit, dat[8:0]},
              {e.pre, 1'b1, e.rd ? 2'b10 : 2'b01, e.phy, e.rg, e.rd ? 2'b00 : 2'b11,
               e.rd ? 2'b00 : 2'b10, e.dat[8:0]});
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            period_cnt++;
            if ((mdio_o !== prev_out || mdio_oe !== prev_oe) && !(prev_mdc && !mdc))
                viol++;
            if (!mdc && prev_mdc) begin
                if (mphase == 3 && cur_rd && dcnt < 16)
                    phy_out = phy_val[15 - dcnt];
                else
                    phy_out = 1'b1;
            end
            if (mdc && !prev_mdc) begin
                last_period = period_cnt;
                period_cnt  = 0;
                case (mphase)
                    0: begin
                        if (!mdio_oe) ones = 0;
                        else if (mdio_i) ones++;
                        else begin mphase = 1; hcnt = 0; end
                    end
                    1: begin
                        h = {h[11:0], mdio_i};
                        hcnt++;
                        if (hcnt == 13) begin
                            mphase = 2; tcnt = 0;
                            cur_rd = (h[11:10] == 2'b10);
                        end
                    end
                    2: begin
                        ta_oe  = {ta_oe[0], mdio_oe};
                        ta_bit = {ta_bit[0], mdio_i};
                        tcnt++;
                        if (tcnt == 2) begin mphase = 3; dcnt = 0; end
                    end
                    default: begin
                        dat = {dat[14:0], mdio_i};
                        dcnt++;
                        if (dcnt == 16) begin
                            finish_frame();
                            mphase = 0; ones = 0;
                        end
                    end
                endcase
            end
        end
        prev_mdc = mdc; prev_out = mdio_o; prev_oe = mdio_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n, m;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        rd(3'd0, v); check(v == 16'h0064, "R1 mode reset", v, 16'h0064);
        rd(3'd1, v); check(v == 16'h0000, "R3 command reset", v, 16'h0);
        rd(3'd2, v); check(v == 16'h0000, "R4 address reset", v, 16'h0);
        rd(3'd4, v); check(v == 16'h0000, "R6 receive data reset", v, 16'h0);
        rd(3'd5, v); check(v == 16'h0000, "R7 status reset", v, 16'h0);
        rd(3'd6, v); check(v == 16'h0000, "R1 unused offset", v, 16'h0);

        repeat (300) @(negedge clk);
        check(last_period == 100, "R12 default period", last_period, 100);

        wr(3'd0, 16'h0004);
        repeat (30) @(negedge clk);
        check(last_period == 4, "R12 period four", last_period, 4);

        wr(3'd2, 16'hEAF5);
        rd(3'd2, v); check(v == 16'h0A15, "R4 address fields", v, 16'h0A15);

        // write frame with preamble
        wr(3'd3, 16'hA5C3);
        push(1'b0, 6'd32, 5'h15, 5'h0A, 16'hA5C3);
        n = frames_seen;
        wr(3'd1, 16'h0004);
        rd(3'd5, v); check(v[1] == 1'b1, "R8 busy after start", v, 16'h0002);
        repeat (10) @(negedge clk);
        rd(3'd1, v); check(v == 16'h0000, "R3 write bit cleared", v, 16'h0);
        wait_idle();
        rd(3'd5, v); check(v == 16'h0000, "R8 busy low after frame", v, 16'h0);
        check(frames_seen == n + 1 && exp_q.size() == 0, "R9 write frame seen",
              frames_seen - n, 1);

        // read frame
        phy_val = 16'h1234;
        push(1'b1, 6'd32, 5'h15, 5'h0A, 16'h0);
        wr(3'd1, 16'h0002);
        repeat (10) @(negedge clk);
        rd(3'd1, v); check(v == 16'h0000, "R3 read bit cleared", v, 16'h0);
        wait_idle();
        rd(3'd4, v); check(v == 16'h1234, "R6 read capture", v, 16'h1234);

        // writes to read-only offsets
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        rd(3'd4, v); check(v == 16'h1234, "R13 receive data kept", v, 16'h1234);
        rd(3'd5, v); check(v == 16'h0000, "R13 status kept", v, 16'h0);

        // preamble suppressed
        wr(3'd0, 16'h0104);
        rd(3'd0, v); check(v == 16'h0104, "R1 mode fields", v, 16'h0104);
        wr(3'd3, 16'h0F0F);
        push(1'b0, 6'd0, 5'h15, 5'h0A, 16'h0F0F);
        n = frames_seen;
        wr(3'd1, 16'h0004);
        wait_idle();
        check(frames_seen == n + 1 && exp_q.size() == 0, "R2 short frame seen",
              frames_seen - n, 1);

        // pending commands and priority
        wr(3'd0, 16'h0004);
        phy_val = 16'hBEEF;
        push(1'b0, 6'd32, 5'h15, 5'h0A, 16'h0F0F);
        push(1'b0, 6'd32, 5'h15, 5'h0A, 16'h0F0F);
        push(1'b1, 6'd32, 5'h15, 5'h0A, 16'h0);
        n = frames_seen;
        wr(3'd1, 16'h0004);
        repeat (40) @(negedge clk);
        wr(3'd1, 16'h0006);
        rd(3'd5, v); check(v[1] == 1'b1, "R11 busy while pending", v, 16'h0002);
        wait_idle();
        check(frames_seen == n + 3 && exp_q.size() == 0, "R11 queued order",
              frames_seen - n, 3);
        rd(3'd4, v); check(v == 16'hBEEF, "R11 R6 read after write", v, 16'hBEEF);

        // scan mode
        wr(3'd2, 16'h0103);
        scan_tpl.rd = 1'b1; scan_tpl.pre = 6'd32; scan_tpl.phy = 5'h03;
        scan_tpl.rg = 5'h01; scan_tpl.dat = 16'h0;
        scan_on = 1'b1;
        phy_val = 16'h0000;
        n = frames_seen;
        wr(3'd1, 16'h0001);
        rd(3'd5, v); check(v[2] == 1'b1, "R7 not-yet-valid set", v, 16'h0004);
        wait_frames(n + 1);
        rd(3'd5, v); check({v[2], v[0]} == 2'b01, "R7 link fail after scan", v, 16'h0001);
        rd(3'd1, v); check(v[0] == 1'b1, "R5 scan bit held", v, 16'h0001);
        phy_val = 16'h0004;
        wait_frames(n + 3);
        rd(3'd5, v); check({v[2], v[0]} == 2'b00, "R7 link good", v, 16'h0000);
        rd(3'd4, v); check(v == 16'h0004, "R6 scan capture", v, 16'h0004);
        wr(3'd1, 16'h0000);
        wait_idle();
        scan_on = 1'b0;
        m = frames_seen;
        repeat (400) @(negedge clk);
        check(frames_seen == m, "R5 scan stopped", frames_seen - m, 0);

        // clamped divider
        wr(3'd0, 16'h0000);
        repeat (30) @(negedge clk);
        check(last_period == 2, "R12 clamped period", last_period, 2);
        check(viol == 0, "R12 line change off falling edge", viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule